// File: doc/BRIEF.md
# Control Cell Capture Buffer

This block keeps recent control cells from several receive links so that software can look at them without racing the traffic. Each link owns a four-slot circular store of 64-byte cells. A whole cell arrives in one transfer on a valid/ready stream, already flagged as good or bad and tagged with its change-indication value. A per-link capture mode decides which good cells are kept: every one of them (start-up), or only those whose change-indication value differs from that of the last cell kept on that link (normal running).

Software sees a 128-byte window per link. The lower half holds the reference cell, which is the last one software moved past. The upper half holds the next pending cell. A per-link level counts pending cells from 0 to 2, where 2 also warns that cells may have been lost. An advance command slides the window on by one cell. Any byte of the window can be read, with one cycle of latency.

The stream never applies back-pressure once reset is released. `in_ready` is low while reset is asserted and high from the first clock edge after it. A cell is taken on every cycle where `in_valid` and `in_ready` are both high. A sender may hold `in_valid` high for back-to-back cells.

Top module: `ctlcell_capture`

## Requirements
- R1: With the link's mode bit `mode_all` at 1, every transfer with `in_good`=1 is stored, and a transfer with `in_good`=0 changes neither the level nor the window.
- R2: With `mode_all` at 0, a good cell is stored only if its `in_chg` differs from the change value of the last cell stored on that link. That value is 0 after reset and is updated by every stored cell. A cell that is not stored leaves the level unchanged.
- R3: The level takes only the values 0, 1 and 2. A stored cell raises it by one, up to 2, where it stays.
- R4: A cell stored while the level is 2 replaces the newest pending cell. The reference cell and the older pending cell are untouched.
- R5: `adv_valid` for a link whose level is above 0 moves the window forward by exactly one cell and lowers the level by one. At level 0 it has no effect.
- R6: At level 0 a stored cell appears at window offsets 64..127, and the reference cell at offsets 0..63 is not overwritten.
- R7: When an advance and a stored cell hit the same link in one cycle, the advance is applied first and the store second.
- R8: `rd_data` returns byte `rd_addr[5:0]` of the reference cell (`rd_addr[6]`=0) or of the next cell (`rd_addr[6]`=1) of link `rd_port`, one cycle after the address. Byte k of a cell is `in_cell[8k+7:8k]`.
- R9: Links are independent. `lvl_out` shows, in the same cycle, the level of the link chosen by `lvl_sel`.
- R10: `in_ready` is 0 during reset and 1 on every cycle after it.
- R11: After reset every level is 0, and every slot reads as all-zero bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| in_valid | input | 1 | cell transfer offered |
| in_ready | output | 1 | cell transfer accepted |
| in_port | input | 2 | receiving link of the cell |
| in_cell | input | 512 | whole cell, byte k in bits 8k+7:8k |
| in_good | input | 1 | cell passed validation |
| in_chg | input | 8 | change-indication value of the cell |
| mode_all | input | 4 | per link: 1 keeps all good cells, 0 keeps only changes |
| adv_valid | input | 1 | advance-window command |
| adv_port | input | 2 | link the advance applies to |
| lvl_sel | input | 2 | link whose level is shown |
| lvl_out | output | 2 | pending-cell level of the chosen link |
| rd_port | input | 2 | link of the byte read |
| rd_addr | input | 7 | byte offset within the 128-byte window |
| rd_data | output | 8 | byte read, one cycle after the address |

## Verification
The bench fills a link past saturation and then advances twice. A design that wrote the extra cell into a fresh slot, instead of over the newest pending one, would show the older cell at the window base. It issues an advance at level 0 and then reads the base. A design that advanced anyway would move the window onto an empty slot. It sends an advance together with a store while the level is 2. Handling the store before the advance would overwrite the wrong cell, which shows up at offset 64. It also sends repeated and bad cells in change mode, where a filter comparing against the wrong value would raise the level.

// File: rtl/ctlcap_pkg.sv
package ctlcap_pkg;
  localparam int CELL_BYTES = 64;
  localparam int CELL_BITS  = CELL_BYTES * 8;
  localparam int BYTE_AW    = $clog2(CELL_BYTES);
  localparam int SLOT_N     = 4;
  localparam int PTR_W      = $clog2(SLOT_N);
  localparam int LVL_W      = 2;
  localparam logic [LVL_W-1:0] LVL_FULL = 2'd2;
  typedef logic [CELL_BITS-1:0] cell_t;
endpackage

// File: rtl/ctlcap_filter.sv
module ctlcap_filter
  import ctlcap_pkg::*;
#(
  parameter int CHG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic             good,
  input  logic [CHG_W-1:0] chg,
  input  logic             mode_all,
  output logic             accept
);
  logic [CHG_W-1:0] last_q;

  assign accept = fire && good && (mode_all || (chg != last_q));

  always_ff @(posedge clk) begin
    if (!rst_n)      last_q <= '0;
    else if (accept) last_q <= chg;
  end
endmodule

// File: rtl/ctlcap_ring.sv
module ctlcap_ring
  import ctlcap_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  cell_t              wr_cell,
  input  logic               adv,
  input  logic               win_hi,
  input  logic [BYTE_AW-1:0] byte_idx,
  output logic [7:0]         byte_out,
  output logic [LVL_W-1:0]   level,
  output logic [PTR_W-1:0]   base_ptr
);
  cell_t                         slot_q [SLOT_N];
  logic [PTR_W-1:0]              ptr_q, ptr_a, wr_idx;
  logic [LVL_W-1:0]              lvl_q, lvl_a, lvl_n;
  logic                          step;
  cell_t                         win_cell;

  always_comb begin
    step   = adv && (lvl_q != '0);
    ptr_a  = step ? ptr_q + PTR_W'(1) : ptr_q;
    lvl_a  = step ? lvl_q - LVL_W'(1) : lvl_q;
    if (lvl_a == LVL_FULL) begin
      wr_idx = ptr_a + PTR_W'(2);
      lvl_n  = LVL_FULL;
    end else begin
      wr_idx = ptr_a + PTR_W'(lvl_a) + PTR_W'(1);
      lvl_n  = lvl_a + LVL_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
      lvl_q <= '0;
    end else begin
      ptr_q <= ptr_a;
      lvl_q <= wr_en ? lvl_n : lvl_a;
    end
  end

  for (genvar s = 0; s < SLOT_N; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)
        slot_q[s] <= '0;
      else if (wr_en && (wr_idx == PTR_W'(s)))
        slot_q[s] <= wr_cell;
    end
  end

  assign win_cell = slot_q[ptr_q + PTR_W'(win_hi)];
  assign byte_out = win_cell[{byte_idx, 3'b000} +: 8];
  assign level    = lvl_q;
  assign base_ptr = ptr_q;
endmodule

// File: rtl/ctlcell_capture.sv
module ctlcell_capture
  import ctlcap_pkg::*;
#(
  parameter int NPORT  = 4,
  parameter int CHG_W  = 8,
  localparam int PORT_W = $clog2(NPORT)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [PORT_W-1:0]    in_port,
  input  logic [CELL_BITS-1:0] in_cell,
  input  logic                 in_good,
  input  logic [CHG_W-1:0]     in_chg,
  input  logic [NPORT-1:0]     mode_all,
  input  logic                 adv_valid,
  input  logic [PORT_W-1:0]    adv_port,
  input  logic [PORT_W-1:0]    lvl_sel,
  output logic [LVL_W-1:0]     lvl_out,
  input  logic [PORT_W-1:0]    rd_port,
  input  logic [BYTE_AW:0]     rd_addr,
  output logic [7:0]           rd_data
);
  logic                              rdy_q;
  logic [NPORT-1:0]                  lane_acc;
  logic [NPORT-1:0]                  lane_adv;
  logic [NPORT-1:0][LVL_W-1:0]       lane_lvl;
  logic [NPORT-1:0][PTR_W-1:0]       lane_ptr;
  logic [NPORT-1:0][7:0]             lane_byte;

  always_ff @(posedge clk) begin
    if (!rst_n) rdy_q <= 1'b0;
    else        rdy_q <= 1'b1;
  end
  assign in_ready = rdy_q;

  for (genvar p = 0; p < NPORT; p++) begin : g_lane
    logic fire;
    assign fire        = in_valid && rdy_q && (in_port == PORT_W'(p));
    assign lane_adv[p] = adv_valid && (adv_port == PORT_W'(p));

    ctlcap_filter #(.CHG_W(CHG_W)) u_filt (
      .clk      (clk),
      .rst_n    (rst_n),
      .fire     (fire),
      .good     (in_good),
      .chg      (in_chg),
      .mode_all (mode_all[p]),
      .accept   (lane_acc[p])
    );

    ctlcap_ring u_ring (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (lane_acc[p]),
      .wr_cell  (in_cell),
      .adv      (lane_adv[p]),
      .win_hi   (rd_addr[BYTE_AW]),
      .byte_idx (rd_addr[BYTE_AW-1:0]),
      .byte_out (lane_byte[p]),
      .level    (lane_lvl[p]),
      .base_ptr (lane_ptr[p])
    );
  end

  assign lvl_out = lane_lvl[lvl_sel];

  always_ff @(posedge clk) begin
    if (!rst_n) rd_data <= '0;
    else        rd_data <= lane_byte[rd_port];
  end
endmodule

// File: rtl/ctlcap_chk.sv
module ctlcap_chk
  import ctlcap_pkg::*;
#(
  parameter int NPORT  = 4,
  parameter int PORT_W = 2
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        in_ready,
  input logic                        adv_valid,
  input logic [PORT_W-1:0]           adv_port,
  input logic [NPORT-1:0]            lane_acc,
  input logic [NPORT-1:0][LVL_W-1:0] lane_lvl,
  input logic [NPORT-1:0][PTR_W-1:0] lane_ptr
);
  a_r10_ready_high: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> in_ready);

  for (genvar p = 0; p < NPORT; p++) begin : g_p
    logic hit;
    assign hit = adv_valid && (adv_port == PORT_W'(p));

    a_r3_level_range: assert property (@(posedge clk) disable iff (!rst_n)
      lane_lvl[p] != 2'd3);

    a_r3_store_raises: assert property (@(posedge clk) disable iff (!rst_n)
      (lane_acc[p] && !hit && lane_lvl[p] != LVL_FULL)
      |=> lane_lvl[p] == LVL_W'($past(lane_lvl[p]) + 2'd1));

    a_r4_full_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
      (lane_acc[p] && !hit && lane_lvl[p] == LVL_FULL)
      |=> (lane_lvl[p] == LVL_FULL) && $stable(lane_ptr[p]));

    a_r5_adv_empty_noop: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !lane_acc[p] && lane_lvl[p] == '0)
      |=> (lane_lvl[p] == '0) && $stable(lane_ptr[p]));

    a_r5_adv_step: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !lane_acc[p] && lane_lvl[p] != '0)
      |=> (lane_lvl[p] == LVL_W'($past(lane_lvl[p]) - 2'd1))
          && (lane_ptr[p] == PTR_W'($past(lane_ptr[p]) + 2'd1)));

    a_r7_adv_then_store: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && lane_acc[p] && lane_lvl[p] != '0)
      |=> (lane_lvl[p] == $past(lane_lvl[p]))
          && (lane_ptr[p] == PTR_W'($past(lane_ptr[p]) + 2'd1)));
  end
endmodule

bind ctlcell_capture ctlcap_chk #(.NPORT(NPORT), .PORT_W(PORT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .adv_valid (adv_valid),
  .adv_port  (adv_port),
  .lane_acc  (lane_acc),
  .lane_lvl  (lane_lvl),
  .lane_ptr  (lane_ptr)
);

// File: tb/ctlcell_capture_test.sv
`timescale 1ns/1ps
module ctlcell_capture_test;
  import ctlcap_pkg::*;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [1:0]   in_port = '0;
  cell_t        in_cell = '0;
  logic         in_good = 1'b0;
  logic [7:0]   in_chg = '0;
  logic [3:0]   mode_all = 4'b1101;
  logic         adv_valid = 1'b0;
  logic [1:0]   adv_port = '0;
  logic [1:0]   lvl_sel = '0;
  logic [1:0]   lvl_out;
  logic [1:0]   rd_port = '0;
  logic [6:0]   rd_addr = '0;
  logic [7:0]   rd_data;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ctlcell_capture uut (.*);

  // vector: kind(1: 0=cell 1=advance) port(2) tag(8) good(1) chg(8) exp_lvl(2) req(4)
  localparam int NV = 14;
  localparam logic [25:0] VEC [NV] = '{
    {1'b0, 2'd0, 8'h11, 1'b1, 8'd0, 2'd1, 4'd1},  // R1 good cell stored
    {1'b0, 2'd0, 8'h12, 1'b0, 8'd0, 2'd1, 4'd1},  // R1 bad cell ignored
    {1'b0, 2'd0, 8'h13, 1'b1, 8'd0, 2'd2, 4'd3},  // R3 level to 2
    {1'b0, 2'd0, 8'h14, 1'b1, 8'd0, 2'd2, 4'd3},  // R3 saturates, R4 overwrite
    {1'b1, 2'd0, 8'h00, 1'b0, 8'd0, 2'd1, 4'd5},  // R5 step
    {1'b1, 2'd0, 8'h00, 1'b0, 8'd0, 2'd0, 4'd5},  // R5 step
    {1'b1, 2'd0, 8'h00, 1'b0, 8'd0, 2'd0, 4'd5},  // R5 no effect at 0
    {1'b0, 2'd1, 8'h21, 1'b1, 8'd0, 2'd0, 4'd2},  // R2 equals reset value
    {1'b0, 2'd1, 8'h22, 1'b1, 8'd5, 2'd1, 4'd2},  // R2 change
    {1'b0, 2'd1, 8'h23, 1'b1, 8'd5, 2'd1, 4'd2},  // R2 repeat dropped
    {1'b0, 2'd1, 8'h24, 1'b1, 8'd3, 2'd2, 4'd2},  // R2 change
    {1'b1, 2'd1, 8'h00, 1'b0, 8'd0, 2'd1, 4'd5},  // R5
    {1'b0, 2'd1, 8'h25, 1'b0, 8'd9, 2'd1, 4'd2},  // R2 bad cell dropped
    {1'b0, 2'd2, 8'h31, 1'b1, 8'd0, 2'd1, 4'd9}   // R9 other link
  };

  function automatic cell_t mk_cell(input logic [7:0] tag);
    cell_t c;
    for (int k = 0; k < CELL_BYTES; k++) c[8*k +: 8] = tag ^ 8'(k);
    return c;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input bit is_adv, input bit is_cell, input logic [1:0] port,
                      input logic [7:0] tag, input bit good, input logic [7:0] chg);
    @(negedge clk);
    in_valid  = is_cell;
    in_port   = port;
    in_cell   = mk_cell(tag);
    in_good   = good;
    in_chg    = chg;
    adv_valid = is_adv;
    adv_port  = port;
    @(negedge clk);
    in_valid  = 1'b0;
    adv_valid = 1'b0;
  endtask

  task automatic rd(input logic [1:0] port, input logic [6:0] addr, output logic [7:0] val);
    @(negedge clk);
    rd_port = port;
    rd_addr = addr;
    @(negedge clk);
    val = rd_data;
  endtask

  task automatic lvl(input string req, input logic [1:0] port, input logic [1:0] exp);
    lvl_sel = port;
    #1;
    check(req, 8'(lvl_out), 8'(exp));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    check("R10 ready in reset", 8'(in_ready), 8'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 ready after reset", 8'(in_ready), 8'd1);
    for (int p = 0; p < 4; p++) lvl("R11 reset level", 2'(p), 2'd0);
    rd(2'd3, 7'd70, v);
    check("R11 reset slot zero", v, 8'h00);

    // table walk
    for (int i = 0; i < NV; i++) begin
      logic [25:0] e;
      string s;
      e = VEC[i];
      step(e[25], !e[25], e[24:23], e[22:15], e[14], e[13:6]);
      s = $sformatf("R%0d vector %0d", e[3:0], i);
      lvl(s, e[24:23], e[5:4]);
    end
    lvl("R9 link0 untouched", 2'd0, 2'd0);

    // link 0: overwrite of newest, base after two advances
    rd(2'd0, 7'd5, v);
    check("R4 newest replaced", v, 8'h14 ^ 8'd5);
    rd(2'd0, 7'd64, v);
    check("R5 advance at 0 held window", v, 8'h00);
    // link 1: byte addressing in both halves
    rd(2'd1, 7'd0, v);
    check("R8 base byte 0", v, 8'h22);
    rd(2'd1, 7'd71, v);
    check("R8 next byte 7", v, 8'h24 ^ 8'd7);
    // link 2: reference kept, top byte of next cell
    rd(2'd2, 7'd0, v);
    check("R6 base kept", v, 8'h00);
    rd(2'd2, 7'd127, v);
    check("R8 last byte", v, 8'h31 ^ 8'd63);

    // link 3: store at level 0, then simultaneous advance and store
    step(1'b0, 1'b1, 2'd3, 8'h41, 1'b1, 8'd0);
    lvl("R3 link3 first", 2'd3, 2'd1);
    rd(2'd3, 7'd1, v);
    check("R6 base not overwritten", v, 8'h00);
    rd(2'd3, 7'd64, v);
    check("R6 new cell at 64", v, 8'h41);
    step(1'b1, 1'b1, 2'd3, 8'h42, 1'b1, 8'd0);
    lvl("R7 adv+store level1", 2'd3, 2'd1);
    step(1'b0, 1'b1, 2'd3, 8'h43, 1'b1, 8'd0);
    lvl("R3 link3 full", 2'd3, 2'd2);
    step(1'b1, 1'b1, 2'd3, 8'h44, 1'b1, 8'd0);
    lvl("R7 adv+store level2", 2'd3, 2'd2);
    rd(2'd3, 7'd2, v);
    check("R7 base after adv", v, 8'h42 ^ 8'd2);
    rd(2'd3, 7'd67, v);
    check("R7 next kept", v, 8'h43 ^ 8'd3);
    lvl("R9 link1 untouched", 2'd1, 2'd1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule